// File: doc/BRIEF.md
# Interrupt Request Qualification and Entry Sequencer

This block sits next to a processor core and decides when one of several I/O devices may interrupt it. Each device presents a ready line, an enable bit, a 3-bit priority level and an 8-bit vector number. At an instruction boundary the block selects the strongest qualified requester. It starts an entry sequence only if that requester outranks the level the processor is currently running at.

The entry sequence is a chain of handshaked steps. First the processor enters supervisor state. The block then asks for the PC, the status word and the stack pointer to be saved. It presents the service-table address of the accepted vector for the handler fetch, and finally asks for the PC to be loaded, at which point it also raises the processor priority to the accepted level. Each step strobe stays high until the surrounding datapath answers with a done pulse. A return-from-interrupt strobe starts the reverse sequence, which restores PC, status word and stack pointer.

A small nesting counter tracks how many handlers are active. The supervisor flag stays set until the outermost handler has returned.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset all step strobes, `raise_prio_o` and `super_o` are low and `vt_addr_o` is zero.
- R2: A device is accepted only in a cycle where it is enabled, ready, above the current level, and `insn_done_i` is high, with the block idle. If any of these is missing, no sequence starts.
- R3: A request whose level equals `cur_prio_i` is rejected. A request one level above it is accepted.
- R4: Among qualified devices the highest level wins. On a tie the lowest device index wins. A disabled device never wins, whatever its level.
- R5: Acceptance is followed on the next clock edge by `super_o` high and `save_pc_o` high. The steps then advance strictly in the order save PC, save status, save SP, fetch vector, load PC, at most one strobe high at a time. Each strobe is held until a cycle with `step_done_i` high.
- R6: During the fetch-vector and load-PC steps, `vt_addr_o` equals `VT_BASE` (default 16'h0100) plus the accepted 8-bit vector, zero-extended. With the default vectors, device d uses vector 8'h20 + d*8'h11.
- R7: During the load-PC step `raise_prio_o` is high and `new_prio_o` carries the accepted level.
- R8: Requests arriving while a sequence is running have no effect on that sequence or on its table address.
- R9: With `super_o` high, an `rti_i` pulse in idle starts the restore steps in the order restore PC, restore status, restore SP, each held until `step_done_i`. When the last one completes, the nesting depth drops by one, and `super_o` falls once the depth reaches zero.
- R10: `rti_i` while `super_o` is low is ignored and starts no step.
- R11: Each accepted entry raises the nesting depth by one. At the maximum depth (2**DEPTH_W - 1, 3 by default), further requests are not accepted.
- R12: If `rti_i` and a qualified request arrive in the same idle cycle, the restore sequence starts and the request is not taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_ready_i | input | N_DEV | Per-device service-needed flag |
| dev_en_i | input | N_DEV | Per-device interrupt permission |
| dev_prio_i | input | N_DEV*PRIO_W | Per-device priority level, device 0 in the low bits |
| dev_vec_i | input | N_DEV*VEC_W | Per-device vector number, device 0 in the low bits |
| cur_prio_i | input | PRIO_W | Priority of the running program |
| insn_done_i | input | 1 | Current instruction has completed |
| rti_i | input | 1 | Return-from-interrupt request |
| step_done_i | input | 1 | Current entry or restore step has finished |
| super_o | output | 1 | Supervisor state |
| save_pc_o | output | 1 | Save PC step |
| save_psr_o | output | 1 | Save status word step |
| save_sp_o | output | 1 | Save stack pointer step |
| fetch_vec_o | output | 1 | Read the service-table entry at vt_addr_o |
| vt_addr_o | output | ADDR_W | Service-table entry address |
| load_pc_o | output | 1 | Load handler address into PC |
| raise_prio_o | output | 1 | Write new_prio_o as the processor level |
| new_prio_o | output | PRIO_W | Accepted priority level |
| rest_pc_o | output | 1 | Restore PC step |
| rest_psr_o | output | 1 | Restore status word step |
| rest_sp_o | output | 1 | Restore stack pointer step |

## Verification
The qualification logic is driven with patterns that each drop exactly one of the four acceptance conditions (enable, ready, level above current, instruction boundary). Each of these should show no sequence start, while the matching full pattern does start one. A level equal to the current one is set against a level one higher to isolate the strict comparison. Multi-device patterns with a tie, a unique maximum and a disabled top-level device tell the priority order apart from the index order. The table address and raised level show which device won. Directed sequences hold steps without done, inject requests mid-sequence, nest entries up to the depth limit, and collide a return with a request, to separate the sequencing and nesting rules.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE_PC,
    ST_SAVE_PSR,
    ST_SAVE_SP,
    ST_FETCH_VEC,
    ST_LOAD_PC,
    ST_RST_PC,
    ST_RST_PSR,
    ST_RST_SP
  } seq_state_e;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_DEV  = 4,
  parameter int PRIO_W = 3,
  parameter int VEC_W  = 8
) (
  input  logic [N_DEV-1:0]        ready_i,
  input  logic [N_DEV-1:0]        en_i,
  input  logic [N_DEV*PRIO_W-1:0] prio_i,
  input  logic [N_DEV*VEC_W-1:0]  vec_i,
  input  logic [PRIO_W-1:0]       cur_prio_i,
  output logic                    hit_o,
  output logic [PRIO_W-1:0]       win_prio_o,
  output logic [VEC_W-1:0]        win_vec_o
);

  logic [N_DEV-1:0] qual;

  for (genvar g = 0; g < N_DEV; g++) begin : g_qual
    assign qual[g] = en_i[g] & ready_i[g] &
                     (prio_i[g*PRIO_W +: PRIO_W] > cur_prio_i);
  end

  // strict compare keeps the lowest index on a tie
  always_comb begin
    hit_o      = 1'b0;
    win_prio_o = '0;
    win_vec_o  = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (qual[i] && (!hit_o || prio_i[i*PRIO_W +: PRIO_W] > win_prio_o)) begin
        hit_o      = 1'b1;
        win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
        win_vec_o  = vec_i[i*VEC_W +: VEC_W];
      end
    end
  end

endmodule

// File: rtl/irq_nest_ctr.sv
module irq_nest_ctr #(
  parameter int DEPTH_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic nz_o
);

  logic [DEPTH_W-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
    end else if (inc_i && !dec_i && !full_o) begin
      depth_q <= depth_q + 1'b1;
    end else if (dec_i && !inc_i && nz_o) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  assign full_o = &depth_q;
  assign nz_o   = |depth_q;

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       rti_go_i,
  input  logic       step_done_i,
  output seq_state_e state_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rti_go_i)      state_d = ST_RST_PC;
        else if (accept_i) state_d = ST_SAVE_PC;
      end
      ST_SAVE_PC:   if (step_done_i) state_d = ST_SAVE_PSR;
      ST_SAVE_PSR:  if (step_done_i) state_d = ST_SAVE_SP;
      ST_SAVE_SP:   if (step_done_i) state_d = ST_FETCH_VEC;
      ST_FETCH_VEC: if (step_done_i) state_d = ST_LOAD_PC;
      ST_LOAD_PC:   if (step_done_i) state_d = ST_IDLE;
      ST_RST_PC:    if (step_done_i) state_d = ST_RST_PSR;
      ST_RST_PSR:   if (step_done_i) state_d = ST_RST_SP;
      ST_RST_SP:    if (step_done_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int              N_DEV   = 4,
  parameter int              PRIO_W  = 3,
  parameter int              VEC_W   = 8,
  parameter int              ADDR_W  = 16,
  parameter int              DEPTH_W = 2,
  parameter logic [ADDR_W-1:0] VT_BASE = 16'h0100
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_DEV-1:0]        dev_ready_i,
  input  logic [N_DEV-1:0]        dev_en_i,
  input  logic [N_DEV*PRIO_W-1:0] dev_prio_i,
  input  logic [N_DEV*VEC_W-1:0]  dev_vec_i,
  input  logic [PRIO_W-1:0]       cur_prio_i,
  input  logic                    insn_done_i,
  input  logic                    rti_i,
  input  logic                    step_done_i,
  output logic                    super_o,
  output logic                    save_pc_o,
  output logic                    save_psr_o,
  output logic                    save_sp_o,
  output logic                    fetch_vec_o,
  output logic [ADDR_W-1:0]       vt_addr_o,
  output logic                    load_pc_o,
  output logic                    raise_prio_o,
  output logic [PRIO_W-1:0]       new_prio_o,
  output logic                    rest_pc_o,
  output logic                    rest_psr_o,
  output logic                    rest_sp_o
);

  seq_state_e        state;
  logic              hit, nest_full, nest_nz, idle, accept, rti_go, rti_end;
  logic [PRIO_W-1:0] win_prio, cap_prio_q;
  logic [VEC_W-1:0]  win_vec, cap_vec_q;

  irq_arbiter #(
    .N_DEV (N_DEV),
    .PRIO_W(PRIO_W),
    .VEC_W (VEC_W)
  ) u_arb (
    .ready_i   (dev_ready_i),
    .en_i      (dev_en_i),
    .prio_i    (dev_prio_i),
    .vec_i     (dev_vec_i),
    .cur_prio_i(cur_prio_i),
    .hit_o     (hit),
    .win_prio_o(win_prio),
    .win_vec_o (win_vec)
  );

  assign idle    = (state == ST_IDLE);
  assign rti_go  = idle & rti_i & nest_nz;
  assign accept  = idle & insn_done_i & hit & ~rti_go & ~nest_full;
  assign rti_end = (state == ST_RST_SP) & step_done_i;

  irq_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .rti_go_i   (rti_go),
    .step_done_i(step_done_i),
    .state_o    (state)
  );

  irq_nest_ctr #(
    .DEPTH_W(DEPTH_W)
  ) u_nest (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (accept),
    .dec_i (rti_end),
    .full_o(nest_full),
    .nz_o  (nest_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_prio_q <= '0;
      cap_vec_q  <= '0;
    end else if (accept) begin
      cap_prio_q <= win_prio;
      cap_vec_q  <= win_vec;
    end
  end

  assign super_o      = nest_nz;
  assign save_pc_o    = (state == ST_SAVE_PC);
  assign save_psr_o   = (state == ST_SAVE_PSR);
  assign save_sp_o    = (state == ST_SAVE_SP);
  assign fetch_vec_o  = (state == ST_FETCH_VEC);
  assign load_pc_o    = (state == ST_LOAD_PC);
  assign raise_prio_o = load_pc_o;
  assign new_prio_o   = cap_prio_q;
  assign rest_pc_o    = (state == ST_RST_PC);
  assign rest_psr_o   = (state == ST_RST_PSR);
  assign rest_sp_o    = (state == ST_RST_SP);
  assign vt_addr_o    = (fetch_vec_o | load_pc_o) ?
                        VT_BASE + ADDR_W'(cap_vec_q) : '0;

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              insn_done_i,
  input logic              rti_i,
  input logic              step_done_i,
  input logic [PRIO_W-1:0] cur_prio_i,
  input logic              super_o,
  input logic              save_pc_o,
  input logic              save_psr_o,
  input logic              save_sp_o,
  input logic              fetch_vec_o,
  input logic [ADDR_W-1:0] vt_addr_o,
  input logic              load_pc_o,
  input logic [PRIO_W-1:0] new_prio_o,
  input logic              rest_pc_o,
  input logic              rest_psr_o,
  input logic              rest_sp_o
);

  logic [7:0] stb;
  assign stb = {save_pc_o, save_psr_o, save_sp_o, fetch_vec_o,
                load_pc_o, rest_pc_o, rest_psr_o, rest_sp_o};

  assert_strobe_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb));
  assert_hold_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_pc_o && !step_done_i |=> save_pc_o);
  assert_pc_to_psr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_pc_o && step_done_i |=> save_psr_o);
  assert_psr_to_sp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_psr_o && step_done_i |=> save_sp_o);
  assert_sp_to_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_sp_o && step_done_i |=> fetch_vec_o);
  assert_fetch_to_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_vec_o && step_done_i |=> load_pc_o && $stable(vt_addr_o));
  assert_super_on_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_pc_o |-> super_o);
  assert_accept_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_pc_o) |-> $past(insn_done_i));
  assert_prio_above_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_pc_o) |-> new_prio_o > $past(cur_prio_i));
  assert_rti_pc_to_psr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rest_pc_o && step_done_i |=> rest_psr_o);
  assert_rti_psr_to_sp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rest_psr_o && step_done_i |=> rest_sp_o);
  assert_rti_needs_super_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rest_pc_o) |-> $past(super_o));
  assert_rti_first_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb == 8'h00) && rti_i && super_o |=> rest_pc_o);

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
  .PRIO_W(PRIO_W),
  .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/irq_entry_ctrl_bench.sv
module irq_entry_ctrl_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  dev_ready_i = '0;
  logic [3:0]  dev_en_i = '0;
  logic [11:0] dev_prio_i = '0;
  logic [31:0] dev_vec_i = {8'h53, 8'h42, 8'h31, 8'h20};
  logic [2:0]  cur_prio_i = '0;
  logic        insn_done_i = 1'b0;
  logic        rti_i = 1'b0;
  logic        step_done_i = 1'b0;
  logic        super_o, save_pc_o, save_psr_o, save_sp_o, fetch_vec_o;
  logic        load_pc_o, raise_prio_o, rest_pc_o, rest_psr_o, rest_sp_o;
  logic [15:0] vt_addr_o;
  logic [2:0]  new_prio_o;
  logic [7:0]  sv;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  irq_entry_ctrl u_irq_entry_ctrl (.*);

  assign sv = {save_pc_o, save_psr_o, save_sp_o, fetch_vec_o,
               load_pc_o, rest_pc_o, rest_psr_o, rest_sp_o};

  // ready[4] en[4] prio dev3..dev0 [12] cur[3] done[1] expected winner[3] (4 = none)
  localparam int NV = 10;
  localparam logic [26:0] TBL [NV] = '{
    {4'b0001, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd4, 3'd2, 1'b1, 3'd0}, // R2 all four hold
    {4'b0001, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd4, 3'd2, 1'b1, 3'd4}, // R2 not enabled
    {4'b0000, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd4, 3'd2, 1'b1, 3'd4}, // R2 not ready
    {4'b0001, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd4, 3'd2, 1'b0, 3'd4}, // R2 no boundary
    {4'b0001, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd2, 3'd2, 1'b1, 3'd4}, // R3 equal
    {4'b0001, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd3, 3'd2, 1'b1, 3'd0}, // R3 one above
    {4'b1111, 4'b1111, 3'd5, 3'd6, 3'd6, 3'd1, 3'd0, 1'b1, 3'd1}, // R4 tie
    {4'b1111, 4'b1111, 3'd7, 3'd6, 3'd6, 3'd6, 3'd0, 1'b1, 3'd3}, // R4 unique max
    {4'b1111, 4'b1011, 3'd5, 3'd7, 3'd4, 3'd1, 3'd0, 1'b1, 3'd3}, // R4 disabled top
    {4'b0010, 4'b0010, 3'd0, 3'd0, 3'd6, 3'd0, 3'd7, 1'b1, 3'd4}  // R3 below current
  };

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(input int d);
    return 16'h0100 + 16'(8'h20 + 8'(d) * 8'h11);
  endfunction

  task automatic pulse_done();
    step_done_i = 1'b1;
    tick();
    step_done_i = 1'b0;
  endtask

  // entry from save-PC step onward; returns to idle
  task automatic run_entry(input logic [15:0] ea, input logic [2:0] ep);
    for (int s = 0; s < 5; s++) begin
      chk(sv == (8'h80 >> s), "R5 step order", sv, 8'h80 >> s);
      if (s == 0) begin
        chk(super_o == 1'b1, "R5 super on entry", super_o, 1);
        tick();
        chk(sv == 8'h80, "R5 hold without done", sv, 8'h80);
      end
      if (s == 3) chk(vt_addr_o == ea, "R6 table address", vt_addr_o, ea);
      if (s == 4) begin
        chk(vt_addr_o == ea, "R6 address at load", vt_addr_o, ea);
        chk(raise_prio_o && new_prio_o == ep, "R7 raised level",
            {raise_prio_o, new_prio_o}, {1'b1, ep});
      end
      pulse_done();
    end
    chk(sv == 8'h00, "R5 back to idle", sv, 0);
  endtask

  task automatic run_rti(input bit exp_super);
    rti_i = 1'b1;
    tick();
    rti_i = 1'b0;
    for (int s = 0; s < 3; s++) begin
      chk(sv == (8'h04 >> s), "R9 restore order", sv, 8'h04 >> s);
      pulse_done();
    end
    chk(sv == 8'h00 && super_o == exp_super, "R9 super after return",
        {sv, super_o}, {8'h00, exp_super});
  endtask

  task automatic request(input int d, input logic [2:0] p, input logic [2:0] cur);
    dev_ready_i = 4'b0001 << d;
    dev_en_i    = 4'b0001 << d;
    dev_prio_i  = 12'(p) << (3 * d);
    cur_prio_i  = cur;
    insn_done_i = 1'b1;
    tick();
    dev_ready_i = '0;
    insn_done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(sv == 8'h00 && !super_o && !raise_prio_o && vt_addr_o == 16'h0,
        "R1 reset state", {sv, super_o, vt_addr_o}, 0);
    rst_ni = 1'b1;
    tick();
    chk(sv == 8'h00 && !super_o, "R1 after release", {sv, super_o}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [26:0] r;
      int          w;
      r           = TBL[v];
      w           = int'(r[2:0]);
      dev_ready_i = r[26:23];
      dev_en_i    = r[22:19];
      dev_prio_i  = r[18:7];
      cur_prio_i  = r[6:4];
      insn_done_i = r[3];
      tick();
      dev_ready_i = '0;
      insn_done_i = 1'b0;
      if (w == 4) begin
        chk(sv == 8'h00 && !super_o, "R2 R3 R4 rejected request", sv, 0);
      end else begin
        chk(sv == 8'h80, "R2 R4 accepted request", sv, 8'h80);
        run_entry(addr_of(w), r[7 + 3*w +: 3]);
        run_rti(1'b0);
      end
    end

    // R8: a higher request during a running sequence changes nothing
    request(0, 3'd4, 3'd0);
    chk(sv == 8'h80, "R8 first accept", sv, 8'h80);
    pulse_done();
    dev_ready_i = 4'b1000;
    dev_en_i    = 4'b1000;
    dev_prio_i  = {3'd7, 9'd0};
    insn_done_i = 1'b1;
    pulse_done();
    chk(sv == 8'h20, "R8 sequence continues", sv, 8'h20);
    pulse_done();
    chk(sv == 8'h10 && vt_addr_o == addr_of(0), "R8 address unchanged",
        vt_addr_o, addr_of(0));
    pulse_done();
    chk(new_prio_o == 3'd4, "R8 level unchanged", new_prio_o, 4);
    dev_ready_i = '0;
    insn_done_i = 1'b0;
    pulse_done();
    chk(sv == 8'h00, "R8 idle after entry", sv, 0);
    run_rti(1'b0);

    // R11: nest to maximum depth
    request(0, 3'd1, 3'd0);
    run_entry(addr_of(0), 3'd1);
    request(1, 3'd2, 3'd1);
    run_entry(addr_of(1), 3'd2);
    request(2, 3'd3, 3'd2);
    run_entry(addr_of(2), 3'd3);
    request(3, 3'd4, 3'd3);
    chk(sv == 8'h00, "R11 full depth rejects", sv, 0);
    run_rti(1'b1);
    run_rti(1'b1);
    run_rti(1'b0);

    // R10: return with no active handler
    rti_i = 1'b1;
    tick();
    rti_i = 1'b0;
    chk(sv == 8'h00 && !super_o, "R10 return ignored", {sv, super_o}, 0);
    tick();
    chk(sv == 8'h00, "R10 still idle", sv, 0);

    // R12: return and request in the same cycle
    request(0, 3'd2, 3'd0);
    run_entry(addr_of(0), 3'd2);
    rti_i       = 1'b1;
    dev_ready_i = 4'b0010;
    dev_en_i    = 4'b0010;
    dev_prio_i  = {6'd0, 3'd5, 3'd0};
    insn_done_i = 1'b1;
    tick();
    rti_i       = 1'b0;
    dev_ready_i = '0;
    insn_done_i = 1'b0;
    chk(sv == 8'h04, "R12 return wins", sv, 8'h04);
    for (int s = 0; s < 3; s++) pulse_done();
    chk(sv == 8'h00 && !super_o, "R12 request not taken", {sv, super_o}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule